// File: doc/BRIEF.md
# Interrupt Acceptance and Priority Arbiter

This block keeps the interrupts waiting on one processor core and decides which of them the core is offered. Vectored requests (fixed and lowest-priority delivery) are held in three bit arrays with one bit per vector: a request array, an in-service array and a trigger-mode array. The other kinds each have a single-entry latch that holds a pending flag and a vector. These kinds are system-management, non-maskable, init, startup and external. Requests arrive one per cycle as a strobe that carries a vector, a delivery-mode code and a level flag.

The arbiter presents one interrupt at a time. It raises a pending flag and reports the kind of the selected interrupt, its vector and, for a vectored interrupt, its trigger mode. The four unmaskable kinds are offered whatever the core's enable flag says. External and vectored interrupts wait for that flag. A vectored interrupt must also outrank the vector now in service and pass the task-priority class compare. When the core pulses the acknowledge strobe, the presented interrupt is consumed. An end-of-interrupt strobe retires the highest in-service vector.

Top module: `intr_accept_arb`

## Requirements
- R1: A request with mode code 000 (fixed) or 001 (lowest priority) sets the request bit of its vector and records its trigger mode: level when the level flag is 1, edge when it is 0. When that vector is selected, `sel_level_o` shows the recorded trigger mode.
- R2: A vectored request whose request bit is already set is dropped. The recorded trigger mode of that vector is left unchanged.
- R3: Requests with codes 010 (system-management), 100 (non-maskable), 101 (init), 110 (startup) and 111 (external) latch a pending flag and a vector for their kind. A further request of a kind that is already pending is ignored, and the first vector is kept.
- R4: A startup request is ignored while the started flag is set. Acknowledging a startup sets the started flag. Acknowledging an init clears it.
- R5: A request with mode code 011 is discarded and changes no state.
- R6: System-management, non-maskable, init and startup are presented whatever the value of `int_en_i`. External and vectored interrupts are presented only while `int_en_i` is 1.
- R7: A vectored interrupt is presented only when two conditions hold. The highest requested vector must be numerically greater than the highest in-service vector, which counts as 0 when nothing is in service. Its upper CLS_W bits must also be greater than the upper CLS_W bits of `tpr_i`.
- R8: Selection order, highest first: system-management (kind 1), non-maskable (kind 2), init (kind 3), startup (kind 4), external (kind 5), then the highest requested vector (kind 6). Kind 0 means nothing is presented.
- R9: An acknowledge while an unmaskable or external kind is presented clears only that kind's pending flag.
- R10: An acknowledge while a vectored interrupt is presented moves that vector from the request array to the in-service array. It becomes the current in-service vector, and the next-highest request may then be presented.
- R11: An end-of-interrupt strobe clears the highest in-service bit. The next-highest in-service vector then becomes the current one.
- R12: After reset nothing is pending: `irq_pending_o` is 0, `sel_kind_o` is 0, `sel_vec_o` is 0 and `sel_level_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | VEC_W | Vector of the request |
| req_mode_i | input | 3 | Delivery-mode code of the request |
| req_level_i | input | 1 | 1 for a level-triggered request, 0 for edge |
| tpr_i | input | VEC_W | Task priority; its upper CLS_W bits form the class |
| int_en_i | input | 1 | Core interrupt-enable flag |
| ack_i | input | 1 | Core accepts the presented interrupt |
| eoi_i | input | 1 | End of the current in-service interrupt |
| irq_pending_o | output | 1 | An interrupt is presented |
| sel_kind_o | output | 3 | Kind of the presented interrupt (0 to 6) |
| sel_vec_o | output | VEC_W | Vector of the presented interrupt |
| sel_level_o | output | 1 | Trigger mode of a presented vectored interrupt |

## Verification
The bench builds the block with VEC_W=5 and CLS_W=3. That gives 32 vectors in eight classes of four. At this size every vector can be crossed with every task-priority value, so the class-compare gate is swept exhaustively. The expected pending flag is derived by shifting and comparing in the bench. The small array also keeps short the nested-service sequences, where several vectors are in service and a lower request stays blocked until an end-of-interrupt, along with the ordering runs that stack every unmaskable kind over an external and a vectored interrupt.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    // delivery-mode codes on req_mode_i
    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    // kind reported on sel_kind_o
    typedef enum logic [2:0] {
        SK_NONE  = 3'd0,
        SK_SMI   = 3'd1,
        SK_NMI   = 3'd2,
        SK_INIT  = 3'd3,
        SK_START = 3'd4,
        SK_EXT   = 3'd5,
        SK_VEC   = 3'd6
    } skind_e;

    // single-entry latches, index order equals selection order
    localparam int NUM_LATCH  = 5;
    localparam int UNMASK_CNT = 4;
    localparam int L_SMI   = 0;
    localparam int L_NMI   = 1;
    localparam int L_INIT  = 2;
    localparam int L_START = 3;
    localparam int L_EXT   = 4;

endpackage

// File: rtl/intr_msb_find.sv
module intr_msb_find #(
    parameter int W     = 256,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     bits_i,
    output logic [IDX_W-1:0] idx_o
);
    // linear scan, later hits overwrite earlier ones: highest set bit wins, 0 when empty
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/intr_select.sv
module intr_select
    import intr_arb_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic [NUM_LATCH-1:0]            pend_i,
    input  logic [NUM_LATCH-1:0][VEC_W-1:0] lvec_i,
    input  logic                            int_en_i,
    input  logic [VEC_W-1:0]                irr_top_i,
    input  logic [VEC_W-1:0]                isv_i,
    input  logic [VEC_W-1:0]                tpr_i,
    output skind_e                          kind_o,
    output logic [VEC_W-1:0]                vec_o
);
    logic vec_ok;

    // a zero irr_top never exceeds isv, so an empty request array never qualifies
    assign vec_ok = (irr_top_i > isv_i) &&
                    (irr_top_i[VEC_W-1 -: CLS_W] > tpr_i[VEC_W-1 -: CLS_W]);

    always_comb begin
        kind_o = SK_NONE;
        vec_o  = '0;
        if (int_en_i && vec_ok) begin
            kind_o = SK_VEC;
            vec_o  = irr_top_i;
        end
        // descending loop: the lowest latch index is applied last and wins
        for (int i = NUM_LATCH - 1; i >= 0; i--) begin
            if (pend_i[i] && ((i < UNMASK_CNT) || int_en_i)) begin
                kind_o = skind_e'(3'(i + 1));
                vec_o  = lvec_i[i];
            end
        end
    end
endmodule

// File: rtl/intr_accept_arb.sv
module intr_accept_arb
    import intr_arb_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [VEC_W-1:0] req_vec_i,
    input  logic [2:0]       req_mode_i,
    input  logic             req_level_i,
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             int_en_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             irq_pending_o,
    output logic [2:0]       sel_kind_o,
    output logic [VEC_W-1:0] sel_vec_o,
    output logic             sel_level_o
);
    localparam int NV = 1 << VEC_W;

    typedef struct packed {
        logic [NV-1:0]                   irr;
        logic [NV-1:0]                   isr;
        logic [NV-1:0]                   tmr;
        logic [NUM_LATCH-1:0]            pend;
        logic [NUM_LATCH-1:0][VEC_W-1:0] lvec;
        logic                            started;
    } st_t;

    st_t              st_d, st_q;
    logic [VEC_W-1:0] irr_top, isv;
    skind_e           kind;
    logic [VEC_W-1:0] vec;
    dmode_e           dm;

    intr_msb_find #(.W(NV), .IDX_W(VEC_W)) u_irr_find (.bits_i(st_q.irr), .idx_o(irr_top));
    intr_msb_find #(.W(NV), .IDX_W(VEC_W)) u_isr_find (.bits_i(st_q.isr), .idx_o(isv));

    intr_select #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_sel (
        .pend_i    (st_q.pend),
        .lvec_i    (st_q.lvec),
        .int_en_i  (int_en_i),
        .irr_top_i (irr_top),
        .isv_i     (isv),
        .tpr_i     (tpr_i),
        .kind_o    (kind),
        .vec_o     (vec)
    );

    assign dm            = dmode_e'(req_mode_i);
    assign irq_pending_o = (kind != SK_NONE);
    assign sel_kind_o    = kind;
    assign sel_vec_o     = vec;
    assign sel_level_o   = (kind == SK_VEC) && st_q.tmr[vec];

    always_comb begin
        st_d = st_q;

        // consume the presented interrupt
        if (ack_i) begin
            case (kind)
                SK_SMI:   st_d.pend[L_SMI] = 1'b0;
                SK_NMI:   st_d.pend[L_NMI] = 1'b0;
                SK_INIT:  begin st_d.pend[L_INIT]  = 1'b0; st_d.started = 1'b0; end
                SK_START: begin st_d.pend[L_START] = 1'b0; st_d.started = 1'b1; end
                SK_EXT:   st_d.pend[L_EXT] = 1'b0;
                SK_VEC:   begin st_d.isr[vec] = 1'b1; st_d.irr[vec] = 1'b0; end
                default:  ;
            endcase
        end

        // retire the highest in-service vector
        if (eoi_i) st_d.isr[isv] = 1'b0;

        // accept a new request, judged against the registered state
        if (req_valid_i) begin
            case (dm)
                DM_FIXED, DM_LOWEST: begin
                    if (!st_q.irr[req_vec_i]) begin
                        st_d.irr[req_vec_i] = 1'b1;
                        st_d.tmr[req_vec_i] = req_level_i;
                    end
                end
                DM_SMI: if (!st_q.pend[L_SMI]) begin
                    st_d.pend[L_SMI] = 1'b1; st_d.lvec[L_SMI] = req_vec_i;
                end
                DM_NMI: if (!st_q.pend[L_NMI]) begin
                    st_d.pend[L_NMI] = 1'b1; st_d.lvec[L_NMI] = req_vec_i;
                end
                DM_INIT: if (!st_q.pend[L_INIT]) begin
                    st_d.pend[L_INIT] = 1'b1; st_d.lvec[L_INIT] = req_vec_i;
                end
                DM_START: if (!st_q.pend[L_START] && !st_q.started) begin
                    st_d.pend[L_START] = 1'b1; st_d.lvec[L_START] = req_vec_i;
                end
                DM_EXT: if (!st_q.pend[L_EXT]) begin
                    st_d.pend[L_EXT] = 1'b1; st_d.lvec[L_EXT] = req_vec_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/intr_arb_chk.sv
module intr_arb_chk
    import intr_arb_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4,
    parameter int NV    = 1 << VEC_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [2:0]           req_mode,
    input logic [VEC_W-1:0]     tpr,
    input logic                 int_en,
    input logic                 ack,
    input logic                 eoi,
    input logic                 pending,
    input logic [2:0]           kind,
    input logic [VEC_W-1:0]     vec,
    input logic [NV-1:0]        irr,
    input logic [NV-1:0]        isr,
    input logic [NUM_LATCH-1:0] pend,
    input logic                 started
);
    // R6
    masked_kinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !int_en) |-> (kind >= 3'd1 && kind <= 3'd4));

    // R7
    class_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 3'd6) |-> (vec[VEC_W-1 -: CLS_W] > tpr[VEC_W-1 -: CLS_W]));

    // R8
    smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[L_SMI] |-> (kind == 3'd1));

    // R5
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd3 && !ack && !eoi) |=>
            ($stable(irr) && $stable(isr) && $stable(pend)));

    // R10
    vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && kind == 3'd6) |=> (isr[$past(vec)] && !irr[$past(vec)]));

    // R4
    start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && kind == 3'd4) |=> started);

    // R9
    nmi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && kind == 3'd1 && pend[L_NMI]) |=> pend[L_NMI]);
endmodule

bind intr_accept_arb intr_arb_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .req_valid (req_valid_i),
    .req_mode  (req_mode_i),
    .tpr       (tpr_i),
    .int_en    (int_en_i),
    .ack       (ack_i),
    .eoi       (eoi_i),
    .pending   (irq_pending_o),
    .kind      (sel_kind_o),
    .vec       (sel_vec_o),
    .irr       (st_q.irr),
    .isr       (st_q.isr),
    .pend      (st_q.pend),
    .started   (st_q.started)
);

// File: tb/intr_accept_arb_test.sv
module intr_accept_arb_test;
    localparam int VW = 5;
    localparam int CW = 3;
    localparam int NV = 1 << VW;

    localparam int M_FIX = 0, M_LOW = 1, M_SMI = 2, M_RSV = 3;
    localparam int M_NMI = 4, M_INIT = 5, M_START = 6, M_EXT = 7;
    localparam int K_NONE = 0, K_SMI = 1, K_NMI = 2, K_INIT = 3;
    localparam int K_START = 4, K_EXT = 5, K_VEC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vec = '0;
    logic [2:0]    req_mode = '0;
    logic          req_level = 1'b0;
    logic [VW-1:0] tpr = '0;
    logic          int_en = 1'b0;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          irq_pending;
    logic [2:0]    sel_kind;
    logic [VW-1:0] sel_vec;
    logic          sel_level;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    intr_accept_arb #(.VEC_W(VW), .CLS_W(CW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_vec_i(req_vec), .req_mode_i(req_mode),
        .req_level_i(req_level), .tpr_i(tpr), .int_en_i(int_en),
        .ack_i(ack), .eoi_i(eoi),
        .irq_pending_o(irq_pending), .sel_kind_o(sel_kind),
        .sel_vec_o(sel_vec), .sel_level_o(sel_level)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic see(input int pend, input int kind, input int v, input string tag);
        chk(int'(irq_pending), pend, tag);
        chk(int'(sel_kind), kind, tag);
        if (pend != 0) chk(int'(sel_vec), v, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 0; ack = 0; eoi = 0; tpr = '0; int_en = 1'b1;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    task automatic send(input int v, input int m, input bit lvl);
        @(negedge clk);
        req_valid = 1; req_vec = VW'(v); req_mode = 3'(m); req_level = lvl;
        @(negedge clk);
        req_valid = 0;
        #1;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        #1;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1;
        @(negedge clk); eoi = 0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R12 reset state
        #1;
        do_reset();
        see(0, K_NONE, 0, "R12 reset");
        chk(int'(sel_vec), 0, "R12 vec");
        chk(int'(sel_level), 0, "R12 level");

        // R7 / R1 exhaustive vector x task-priority sweep
        for (int v = 0; v < NV; v++) begin
            do_reset();
            send(v, (v % 2 == 1) ? M_LOW : M_FIX, (v % 3) == 0);
            for (int t = 0; t < NV; t++) begin
                int exp_p;
                tpr = VW'(t);
                #1;
                exp_p = ((v > 0) && ((v >> (VW - CW)) > (t >> (VW - CW)))) ? 1 : 0;
                chk(int'(irq_pending), exp_p, "R7 class gate");
                if (exp_p != 0) begin
                    chk(int'(sel_vec), v, "R1 vector");
                    chk(int'(sel_level), ((v % 3) == 0) ? 1 : 0, "R1 trigger");
                end
            end
        end

        // R2 duplicate vectored request dropped
        do_reset();
        send(9, M_FIX, 1'b1);
        send(9, M_LOW, 1'b0);
        see(1, K_VEC, 9, "R2 duplicate");
        chk(int'(sel_level), 1, "R2 trigger kept");
        send(13, M_FIX, 1'b0);
        see(1, K_VEC, 13, "R1 higher edge");
        chk(int'(sel_level), 0, "R1 edge trigger");

        // R6 / R8 ordering and enable gating
        do_reset();
        int_en = 1'b0;
        send(30, M_FIX, 1'b0);
        send(7, M_EXT, 1'b0);
        see(0, K_NONE, 0, "R6 masked");
        int_en = 1'b1; #1;
        see(1, K_EXT, 7, "R8 ext over vec");
        send(17, M_START, 1'b0);
        see(1, K_START, 17, "R8 start over ext");
        send(18, M_INIT, 1'b0);
        see(1, K_INIT, 18, "R8 init over start");
        send(2, M_NMI, 1'b0);
        see(1, K_NMI, 2, "R8 nmi over init");
        send(3, M_SMI, 1'b0);
        see(1, K_SMI, 3, "R8 smi first");
        int_en = 1'b0; #1;
        see(1, K_SMI, 3, "R6 smi unmasked");
        do_ack();
        see(1, K_NMI, 2, "R9 smi ack keeps nmi");
        do_ack();
        see(1, K_INIT, 18, "R9 nmi ack");
        do_ack();
        see(1, K_START, 17, "R9 init ack");
        do_ack();
        see(0, K_NONE, 0, "R6 ext masked");
        int_en = 1'b1; #1;
        see(1, K_EXT, 7, "R9 ext kept");
        do_ack();
        see(1, K_VEC, 30, "R9 ext ack");
        do_ack();
        see(0, K_NONE, 0, "R10 vec ack");

        // R3 single-entry latch
        do_reset();
        send(5, M_NMI, 1'b0);
        send(9, M_NMI, 1'b0);
        see(1, K_NMI, 5, "R3 repeat ignored");
        do_ack();
        see(0, K_NONE, 0, "R9 nmi cleared");
        send(9, M_NMI, 1'b0);
        see(1, K_NMI, 9, "R3 relatch");

        // R4 startup suppression
        do_reset();
        send(20, M_START, 1'b0);
        do_ack();
        send(21, M_START, 1'b0);
        see(0, K_NONE, 0, "R4 started blocks");
        send(1, M_INIT, 1'b0);
        do_ack();
        send(22, M_START, 1'b0);
        see(1, K_START, 22, "R4 init reopens");

        // R5 reserved code
        do_reset();
        send(20, M_RSV, 1'b0);
        see(0, K_NONE, 0, "R5 reserved");

        // R10 / R11 nested service
        do_reset();
        send(20, M_FIX, 1'b0);
        send(10, M_FIX, 1'b0);
        see(1, K_VEC, 20, "R10 top");
        do_ack();
        see(0, K_NONE, 0, "R7 blocked by isv");
        send(25, M_FIX, 1'b1);
        see(1, K_VEC, 25, "R7 nests");
        do_ack();
        see(0, K_NONE, 0, "R10 isv 25");
        do_eoi();
        see(0, K_NONE, 0, "R11 isv back 20");
        do_eoi();
        see(1, K_VEC, 10, "R11 isv empty");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule